// File: doc/BRIEF.md
# Capture/Compare Timer

This block is an up-counting timer whose counter advances by one on every system-clock cycle where a count enable is high. Two data registers sit beside the counter. Each register can be set to compare mode, where it raises a match pulse when the counter equals it. It can instead be set to capture mode, where it stores the counter value when a capture trigger arrives. Three counting modes are available: free-running, restart when the counter equals register 0, and restart on a capture trigger.

An overflow flag records every step that carries the counter out of its all-ones value. This includes the case where register 0 holds all-ones in restart-on-match mode. Software clears the flag by writing 0 to it. A clear issued in the wrap step, or before the following count step, is overridden so that no overflow is lost. A capture always updates its register, even when a bus write or read of that register falls in the same cycle. A read in that cycle returns an unspecified value.

Top module: `cap_cmp_timer`

## Requirements
- R1: After reset, the counter, both data registers, the control register and the overflow flag read 0. All interrupt pulses are low, and the mode is free-running with both registers in compare role.
- R2: The counter changes only in cycles where `cnt_en` is 1. Each such step adds one unless a restart applies. In all other cycles the counter holds.
- R3: A step taken while the counter is all-ones takes it to 0 and sets the overflow flag. Status bit 0 reads 1 after that step.
- R4: In restart-on-match mode (mode code 1), a step taken while the counter equals register 0 (compare role) loads 0. `irq_match0` is high for exactly the one cycle after that step. When register 0 is all-ones, that step also sets the overflow flag.
- R5: In restart-on-trigger mode (mode code 2), a step with `cap_trig` = 1 loads 0 into the counter. `cap_trig` in a cycle with `cnt_en` = 0 has no effect on the counter or the registers.
- R6: A step with `cap_trig` = 1 loads the pre-step counter value into every register in capture role. `irq_cap` is high for the following cycle. The capture wins over a bus write to that register in the same cycle.
- R7: A write to address 3 with bit 0 = 0 clears the overflow flag outside the protected window. A write with bit 0 = 1 never sets it.
- R8: A clear issued in the wrap step, or after it but before the next count step, leaves the overflow flag at 1.
- R9: Address map (3-bit): 0 = register 0, 1 = register 1, 2 = control, 3 = status (bit 0 is the overflow flag), 4 = counter (read only). Control bits [1:0] select the mode (0 free-running, 1 restart on match, 2 restart on trigger, 3 treated as free-running). Bit 2 and bit 3 put register 0 and register 1 in capture role. `bus_rdata` is 0 when `bus_rd` is 0.
- R10: A step taken while the counter equals register 1 (compare role) makes `irq_match1` high for the following cycle. This has no effect on the count sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_en | input | 1 | Count-clock enable; one step per high cycle |
| cap_trig | input | 1 | Qualified capture edge, acted on in step cycles |
| bus_addr | input | 3 | Register address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | WIDTH | Write data |
| bus_rdata | output | WIDTH | Read data (combinational) |
| ovf_flag | output | 1 | Overflow flag |
| irq_match0 | output | 1 | Register 0 compare-match pulse |
| irq_match1 | output | 1 | Register 1 compare-match pulse |
| irq_cap | output | 1 | Capture pulse |

## Verification
The assertions check on every cycle that the counter holds without an enable and wraps to zero from all-ones. They also check that a trigger step restarts the counter in trigger mode, that every wrap sets the flag, that a guarded clear never drops it, that captures load the pre-step count, and that a match step produces its pulse. Other behaviour is shown only by the bench scenarios: the address map, a successful clear after the window closes, and the overflow seen through restart-on-match with an all-ones compare value. The same applies to the capture winning over a same-cycle write and to a trigger being ignored without an enable.

// File: rtl/cct_pkg.sv
// Package: shared types and address codes for the capture/compare timer.
// Assumes a 3-bit register address on the bus.
package cct_pkg;

    typedef enum logic [1:0] {
        MODE_FREE      = 2'd0,
        MODE_CLR_MATCH = 2'd1,
        MODE_CLR_TRIG  = 2'd2,
        MODE_RSVD      = 2'd3
    } tmr_mode_e;

    localparam int          ADDR_W      = 3;
    localparam int          NUM_CC      = 2;
    localparam logic [2:0]  A_CC0       = 3'd0;
    localparam logic [2:0]  A_CC1       = 3'd1;
    localparam logic [2:0]  A_CTRL      = 3'd2;
    localparam logic [2:0]  A_STATUS    = 3'd3;
    localparam logic [2:0]  A_COUNT     = 3'd4;

endpackage

// File: rtl/tmr_count_core.sv
// Module: counter core. Steps once per enabled cycle and restarts on a
// match of register 0 or on a trigger, depending on the mode.
// Reports a wrap whenever a step leaves the all-ones value.
// Assumes match0 is already qualified by register 0's compare role.
module tmr_count_core
    import cct_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  tmr_mode_e        mode,
    input  logic             cap_trig,
    input  logic             match0,
    output logic [WIDTH-1:0] cnt_q,
    output logic             wrap
);

    localparam logic [WIDTH-1:0] CNT_MAX = '1;

    logic [WIDTH-1:0] cnt_d;
    logic             restart;

    // Next-count selection: restart, increment or hold.
    always_comb begin
        restart = (mode == MODE_CLR_TRIG  && cap_trig) ||
                  (mode == MODE_CLR_MATCH && match0);
        cnt_d   = cnt_q;
        if (step) begin
            cnt_d = restart ? '0 : cnt_q + 1'b1;
        end
        wrap = step && (cnt_q == CNT_MAX);
    end

    // Counter register.
    always_ff @(posedge clk) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    AST_HOLD_NO_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        !step |=> $stable(cnt_q)); // R2
    AST_WRAP_TO_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (step && cnt_q == CNT_MAX) |=> (cnt_q == '0)); // R3
    AST_TRIG_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        (step && mode == MODE_CLR_TRIG && cap_trig) |=> (cnt_q == '0)); // R5

endmodule

// File: rtl/tmr_ovf_flag.sv
// Module: overflow flag with a protected window. A wrap sets the flag.
// A software clear is refused during the wrap step and until the next
// count step has passed.
// Assumes clr_req is a one-cycle request decoded from the bus.
module tmr_ovf_flag (
    input  logic clk,
    input  logic rst_n,
    input  logic step,
    input  logic wrap,
    input  logic clr_req,
    output logic ovf_q
);

    logic guard_q;

    // Flag update: a wrap wins, otherwise an unguarded clear takes effect.
    always_ff @(posedge clk) begin
        if (!rst_n)                    ovf_q <= 1'b0;
        else if (wrap)                 ovf_q <= 1'b1;
        else if (clr_req && !guard_q)  ovf_q <= 1'b0;
    end

    // Guard window: opens on the wrap step, closes on the following step.
    always_ff @(posedge clk) begin
        if (!rst_n)    guard_q <= 1'b0;
        else if (step) guard_q <= wrap;
    end

    AST_WRAP_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        wrap |=> ovf_q); // R3
    AST_GUARDED_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (guard_q && clr_req) |=> ovf_q); // R8

endmodule

// File: rtl/tmr_cc_regs.sv
// Module: bank of capture/compare registers. A register in capture role
// loads the count on a trigger step, and a capture beats a bus write.
// A register in compare role raises a match pulse on a step at equality.
// Assumes wr_sel is one-hot or zero.
module tmr_cc_regs #(
    parameter int WIDTH = 16,
    parameter int NREG  = 2
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       step,
    input  logic                       cap_trig,
    input  logic [NREG-1:0]            cap_role,
    input  logic [WIDTH-1:0]           cnt,
    input  logic [NREG-1:0]            wr_sel,
    input  logic [WIDTH-1:0]           wdata,
    output logic [NREG-1:0][WIDTH-1:0] cc_q,
    output logic [NREG-1:0]            match_now,
    output logic [NREG-1:0]            irq_match,
    output logic                       irq_cap
);

    logic cap_step;
    assign cap_step = step && cap_trig;

    for (genvar i = 0; i < NREG; i++) begin : g_cc
        assign match_now[i] = !cap_role[i] && (cnt == cc_q[i]);

        // Register i: capture has priority over a bus write.
        always_ff @(posedge clk) begin
            if (!rst_n)                       cc_q[i] <= '0;
            else if (cap_step && cap_role[i]) cc_q[i] <= cnt;
            else if (wr_sel[i])               cc_q[i] <= wdata;
        end

        // Match pulse i: one cycle after a step at equality.
        always_ff @(posedge clk) begin
            if (!rst_n) irq_match[i] <= 1'b0;
            else        irq_match[i] <= step && match_now[i];
        end

        AST_CAPTURE_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
            (cap_step && cap_role[i]) |=> (cc_q[i] == $past(cnt))); // R6
        AST_MATCH_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
            (step && match_now[i]) |=> irq_match[i]); // R4
    end

    // Capture pulse: one cycle after a trigger step.
    always_ff @(posedge clk) begin
        if (!rst_n) irq_cap <= 1'b0;
        else        irq_cap <= cap_step;
    end

endmodule

// File: rtl/cap_cmp_timer.sv
// Module: top of the capture/compare timer. Holds the control register,
// decodes the bus and muxes read data. The counter, the flag and the
// register bank live in the submodules.
// Assumes WIDTH >= 4 so the control fields fit in the data bus.
module cap_cmp_timer
    import cct_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cnt_en,
    input  logic              cap_trig,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [WIDTH-1:0]  bus_wdata,
    output logic [WIDTH-1:0]  bus_rdata,
    output logic              ovf_flag,
    output logic              irq_match0,
    output logic              irq_match1,
    output logic              irq_cap
);

    localparam int CTRL_W = 4;

    logic [CTRL_W-1:0]           ctrl_q;
    tmr_mode_e                   mode;
    logic [NUM_CC-1:0]           cap_role;
    logic [NUM_CC-1:0]           wr_sel;
    logic [NUM_CC-1:0][WIDTH-1:0] cc_q;
    logic [NUM_CC-1:0]           match_now;
    logic [NUM_CC-1:0]           irq_match;
    logic [WIDTH-1:0]            cnt_q;
    logic                        wrap;
    logic                        clr_req;

    assign mode     = tmr_mode_e'(ctrl_q[1:0]);
    assign cap_role = ctrl_q[3:2];
    assign clr_req  = bus_wr && (bus_addr == A_STATUS) && !bus_wdata[0];

    for (genvar i = 0; i < NUM_CC; i++) begin : g_wsel
        assign wr_sel[i] = bus_wr && (bus_addr == ADDR_W'(i));
    end

    // Control register: mode and register roles.
    always_ff @(posedge clk) begin
        if (!rst_n)                              ctrl_q <= '0;
        else if (bus_wr && bus_addr == A_CTRL)   ctrl_q <= bus_wdata[CTRL_W-1:0];
    end

    // Read mux: combinational, gated by the read strobe.
    always_comb begin
        bus_rdata = '0;
        if (bus_rd) begin
            unique case (bus_addr)
                A_CC0:    bus_rdata = cc_q[0];
                A_CC1:    bus_rdata = cc_q[1];
                A_CTRL:   bus_rdata = WIDTH'(ctrl_q);
                A_STATUS: bus_rdata = WIDTH'(ovf_flag);
                A_COUNT:  bus_rdata = cnt_q;
                default:  bus_rdata = '0;
            endcase
        end
    end

    tmr_count_core #(.WIDTH(WIDTH)) u_core (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (cnt_en),
        .mode     (mode),
        .cap_trig (cap_trig),
        .match0   (match_now[0]),
        .cnt_q    (cnt_q),
        .wrap     (wrap)
    );

    tmr_ovf_flag u_ovf (
        .clk     (clk),
        .rst_n   (rst_n),
        .step    (cnt_en),
        .wrap    (wrap),
        .clr_req (clr_req),
        .ovf_q   (ovf_flag)
    );

    tmr_cc_regs #(.WIDTH(WIDTH), .NREG(NUM_CC)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .step      (cnt_en),
        .cap_trig  (cap_trig),
        .cap_role  (cap_role),
        .cnt       (cnt_q),
        .wr_sel    (wr_sel),
        .wdata     (bus_wdata),
        .cc_q      (cc_q),
        .match_now (match_now),
        .irq_match (irq_match),
        .irq_cap   (irq_cap)
    );

    assign irq_match0 = irq_match[0];
    assign irq_match1 = irq_match[1];

    AST_SOFT_NO_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf_flag && !wrap) |=> !ovf_flag); // R7

endmodule

// File: tb/cap_cmp_timer_test.sv
// Scoreboard bench: driver tasks queue expected read data, and a monitor
// compares bus_rdata against it at each falling edge of a read cycle.
module cap_cmp_timer_test;

    localparam int W = 8;
    localparam logic [W-1:0] MAXV = '1;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnt_en = 1'b0;
    logic         cap_trig = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic         bus_wr = 1'b0;
    logic         bus_rd = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;
    logic         ovf_flag, irq_match0, irq_match1, irq_cap;

    typedef struct {
        int           req;
        logic [W-1:0] exp;
        bit           any;
    } item_t;

    item_t sb_q[$];
    int    n_vec = 0;
    int    n_bad = 0;
    bit    done  = 1'b0;

    always #4 clk = ~clk;

    cap_cmp_timer #(.WIDTH(W)) uut (
        .clk(clk), .rst_n(rst_n), .cnt_en(cnt_en), .cap_trig(cap_trig),
        .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_flag(ovf_flag),
        .irq_match0(irq_match0), .irq_match1(irq_match1), .irq_cap(irq_cap)
    );

    // Monitor: pop one expected item per read cycle and compare.
    always @(negedge clk) begin
        if (rst_n && bus_rd) begin
            item_t it;
            n_vec++;
            if (sb_q.size() == 0) begin
                n_bad++;
                $display("FAIL R9 unexpected read: actual %h expected none", bus_rdata);
            end else begin
                it = sb_q.pop_front();
                if (!it.any && bus_rdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL R%0d read addr %0d: actual %h expected %h",
                             it.req, bus_addr, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic rd(input logic [2:0] a, input logic [W-1:0] e, input int r);
        bus_addr = a;
        bus_rd   = 1'b1;
        sb_q.push_back('{req: r, exp: e, any: 1'b0});
        tick();
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [2:0] a, input logic [W-1:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr = 1'b0;
    endtask

    task automatic steps(input int n);
        cnt_en = 1'b1;
        repeat (n) tick();
        cnt_en = 1'b0;
    endtask

    task automatic chk(input string what, input int r, input logic act_unused,
                       input logic exp);
        @(negedge clk);
        n_vec++;
        begin
            logic act;
            case (what)
                "irq_match0": act = irq_match0;
                "irq_match1": act = irq_match1;
                "irq_cap":    act = irq_cap;
                default:      act = ovf_flag;
            endcase
            if (act !== exp) begin
                n_bad++;
                $display("FAIL R%0d %s: actual %b expected %b", r, what, act, exp);
            end
        end
        if (act_unused === 1'bz) $display("unreachable");
        tick();
    endtask

    initial begin
        #(8 * 150000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) tick();
        rst_n = 1'b1;
        tick();

        // R1: reset state
        rd(3'd0, 8'h00, 1); rd(3'd1, 8'h00, 1); rd(3'd2, 8'h00, 1);
        rd(3'd3, 8'h00, 1); rd(3'd4, 8'h00, 1);
        chk("irq_match0", 1, 1'b0, 1'b0);
        chk("irq_cap",    1, 1'b0, 1'b0);
        chk("ovf",        1, 1'b0, 1'b0);

        // R2: hold without enable, then five steps
        repeat (3) tick();
        rd(3'd4, 8'd0, 2);
        steps(5);
        rd(3'd4, 8'd5, 2);

        // R3: free-running wrap sets the flag
        steps(250);
        rd(3'd4, MAXV, 3);
        rd(3'd3, 8'h00, 3);
        steps(1);
        rd(3'd4, 8'd0, 3);
        rd(3'd3, 8'h01, 3);

        // R7: clear after the window closes; writing 1 never sets
        steps(1);
        wr(3'd3, 8'h00);
        rd(3'd3, 8'h00, 7);
        wr(3'd3, 8'h01);
        rd(3'd3, 8'h00, 7);

        // R8: clear in the wrap step and inside the window is ignored
        steps(254);
        rd(3'd4, MAXV, 8);
        cnt_en = 1'b1; bus_addr = 3'd3; bus_wdata = 8'h00; bus_wr = 1'b1;
        tick();
        cnt_en = 1'b0; bus_wr = 1'b0;
        rd(3'd3, 8'h01, 8);
        wr(3'd3, 8'h00);
        rd(3'd3, 8'h01, 8);
        steps(1);
        wr(3'd3, 8'h00);
        rd(3'd3, 8'h00, 7);

        // R4: restart on match of register 0; R9 control read back
        wr(3'd2, 8'h01);
        rd(3'd2, 8'h01, 9);
        wr(3'd0, 8'd10);
        rd(3'd0, 8'd10, 9);
        steps(9);
        rd(3'd4, 8'd10, 4);
        steps(1);
        chk("irq_match0", 4, 1'b0, 1'b1);
        chk("irq_match0", 4, 1'b0, 1'b0);
        rd(3'd4, 8'd0, 4);

        // R4: all-ones compare value in restart-on-match still flags overflow
        wr(3'd0, MAXV);
        steps(255);
        rd(3'd4, MAXV, 4);
        rd(3'd3, 8'h00, 4);
        steps(1);
        chk("irq_match0", 4, 1'b0, 1'b1);
        rd(3'd3, 8'h01, 4);
        rd(3'd4, 8'd0, 4);
        steps(1);
        wr(3'd3, 8'h00);

        // R10: register 1 compare pulse, count continues in free-running
        wr(3'd2, 8'h00);
        wr(3'd1, 8'd5);
        steps(4);
        rd(3'd4, 8'd5, 10);
        steps(1);
        chk("irq_match1", 10, 1'b0, 1'b1);
        chk("irq_match1", 10, 1'b0, 1'b0);
        rd(3'd4, 8'd6, 10);

        // R5, R6: restart-on-trigger, register 1 in capture role, read collision
        wr(3'd2, 8'h0A);
        steps(6);
        cnt_en = 1'b1; cap_trig = 1'b1; bus_addr = 3'd1; bus_rd = 1'b1;
        sb_q.push_back('{req: 6, exp: '0, any: 1'b1});
        tick();
        cnt_en = 1'b0; cap_trig = 1'b0; bus_rd = 1'b0;
        chk("irq_cap", 6, 1'b0, 1'b1);
        rd(3'd1, 8'd12, 6);
        rd(3'd4, 8'd0, 5);

        // R6: capture wins over a same-cycle write
        steps(3);
        cnt_en = 1'b1; cap_trig = 1'b1; bus_addr = 3'd1; bus_wdata = 8'h77; bus_wr = 1'b1;
        tick();
        cnt_en = 1'b0; cap_trig = 1'b0; bus_wr = 1'b0;
        rd(3'd1, 8'd3, 6);
        rd(3'd4, 8'd0, 5);

        // R5: trigger without enable is ignored
        cap_trig = 1'b1;
        tick();
        cap_trig = 1'b0;
        chk("irq_cap", 5, 1'b0, 1'b0);
        rd(3'd1, 8'd3, 5);
        rd(3'd4, 8'd0, 5);

        // R6: capture in free-running mode does not restart the count
        wr(3'd2, 8'h08);
        steps(4);
        cnt_en = 1'b1; cap_trig = 1'b1;
        tick();
        cnt_en = 1'b0; cap_trig = 1'b0;
        rd(3'd1, 8'd4, 6);
        rd(3'd4, 8'd5, 6);

        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL R9 scoreboard left %0d items: actual %0d expected 0",
                     sb_q.size(), sb_q.size());
        end
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule